// File: doc/BRIEF.md
# Dual-Source Clock Output Divider

This block turns one of two reference clocks into a divided clock on a single output pin. The references are a low-speed 32768 Hz clock and a high-speed clock of roughly 4 MHz. Both arrive as levels that are synchronous to the block's system clock `clk`. Each rising edge of a reference is detected at the `clk` edge that samples it. One 8-bit control register sets the output. It holds an enable bit, a source select bit, a power-of-two post-divider code and a pre-divider code. The pre-divider code matters only when the high-speed reference is selected. A simple synchronous write port loads the register, and a read port returns it.

The total ratio N is the pre-divider ratio times the post-divider ratio. A single counter, stepped by rising edges of the selected reference, produces the output. For each period of N edges, the output is high for the first N/2 edges and low for the rest. When N is 1, the sampled reference passes straight through. A write that changes the effective ratio or the source starts a fresh period at the next rising edge of the selected reference. Enabling or disabling the output never moves the phase. Three output pins are built by placing the block three times.

Top module: `clkout_div_top`

## Requirements
- R1: Control bit 0 is the output enable. While it is 0, `clk_out` is low. The divider keeps counting while the output is disabled, so setting the bit again resumes the same phase.
- R2: Control bit 4 selects the source: 0 for the low-speed input `src_slow`, 1 for the high-speed input `src_fast`. Only rising edges of the selected input advance the divider. The output changes at the same `clk` edge that samples such a rising edge.
- R3: Control bits 7:5 hold the pre-divider code. With the high-speed source selected, codes 0 through 6 divide by 2 raised to the code (1 to 64).
- R4: Pre-divider code 7 divides by 122.
- R5: With the low-speed source selected, the pre-divider ratio is 1. A write that changes only bits 7:5 leaves the output waveform and its phase untouched.
- R6: Control bits 3:1 hold the post-divider code. It multiplies the ratio by 2 raised to the code, so it adds a factor of 1 to 128.
- R7: For a total ratio N of 2 or more, `clk_out` is high for N/2 selected-source periods and low for N/2 periods. With ratio 122, the high time is 61 source periods.
- R8: A write that changes the source select, the post-divider code, or (with the high-speed source) the pre-divider code starts a new period at the next selected rising edge, with the output going high. A write that leaves these fields unchanged does not shift the phase.
- R9: When the total ratio is 1 and the output is enabled, `clk_out` equals the selected source as sampled at the most recent `clk` edge.
- R10: `rd_data` returns all eight bits of the last value written. The value is visible from the `clk` edge that takes the write.
- R11: After reset the control register reads 0 and `clk_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; references and register port are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_slow | input | 1 | Low-speed reference level (32768 Hz) |
| src_fast | input | 1 | High-speed reference level (about 4 MHz) |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Control value to write |
| rd_data | output | 8 | Current control register value |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
A corrupted counter or a stale restart flag shows up on `clk_out` as a high or low run of the wrong length. This becomes visible within one output period, which is at most N selected-source edges after the fault. A wrong decode of the ratio fields changes the waveform at the first edge of the new period. A restart that fires when it should not, for example on an enable toggle or on a low-speed pre-divider write, shows as a phase jump at the next selected rising edge. The bench compares `clk_out` against an arithmetic edge-index model on every cycle, so each of these faults is caught at the first cycle where the waveforms part.

// File: rtl/clkout_div_pkg.sv
package clkout_div_pkg;

  localparam int unsigned CFG_W  = 8;
  localparam int unsigned PRE_W  = 3;
  localparam int unsigned POST_W = 3;
  localparam int unsigned KEY_W  = 1 + PRE_W + POST_W;

  // Field order is the register layout: pre[7:5], sel[4], post[3:1], en[0]
  typedef struct packed {
    logic [PRE_W-1:0]  pre;
    logic              sel;
    logic [POST_W-1:0] post;
    logic              en;
  } cfg_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pre-divider ratio: all-ones code uses the special top ratio
  function automatic int unsigned pre_ratio(input logic [PRE_W-1:0] code,
                                            input int unsigned top_ratio);
    if (code == {PRE_W{1'b1}}) return top_ratio;
    return 32'd1 << code;
  endfunction

  // Total ratio: pre-divider applies only to the high-speed source
  function automatic int unsigned total_ratio(input cfg_t c, input int unsigned top_ratio);
    int unsigned base;
    base = c.sel ? pre_ratio(c.pre, top_ratio) : 32'd1;
    return base << c.post;
  endfunction

  // Fields that define the waveform; a change here forces a restart
  function automatic logic [KEY_W-1:0] cfg_key(input cfg_t c);
    return {c.sel, c.post, (c.sel ? c.pre : {PRE_W{1'b0}})};
  endfunction

endpackage

// File: rtl/clkout_cfg_reg.sv
module clkout_cfg_reg
  import clkout_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg_q,
  output logic             restart_req
);

  cfg_t wr_cfg;
  assign wr_cfg = cfg_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_cfg;
  end

  // Enable-only or identical writes keep the running phase
  assign restart_req = wr_en && (cfg_key(wr_cfg) != cfg_key(cfg_q));

  assert_cfg_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (CFG_W'(cfg_q) == $past(wr_data)));

endmodule

// File: rtl/clkout_src_edge.sv
module clkout_src_edge #(
  parameter int unsigned NUM_SRC = 2,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               sel_level,
  output logic               sel_rise
);

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_in;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
    assign rise[g] = src_in[g] & ~prev_q[g];
  end

  assign sel_level = prev_q[sel];
  assign sel_rise  = rise[sel];

endmodule

// File: rtl/clkout_div_core.sv
module clkout_div_core #(
  parameter int unsigned RAT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_rise,
  input  logic             restart_req,
  input  logic [RAT_W-1:0] ratio,
  input  logic [RAT_W-1:0] half,
  output logic             div_q
);

  logic [RAT_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;
  logic             div_n;
  logic             restart_take;
  logic             wrap_evt;

  assign restart_take = src_rise && pend_q;
  assign wrap_evt     = src_rise && !pend_q && (cnt_q >= ratio - RAT_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    div_n = div_q;
    if (src_rise) begin
      if (restart_take || wrap_evt) cnt_n = '0;
      else                          cnt_n = cnt_q + RAT_W'(1);
      div_n = (cnt_n < half);
    end
  end

  always_comb begin
    pend_n = pend_q;
    if (src_rise)    pend_n = 1'b0;
    if (restart_req) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_n;
      div_q  <= div_n;
      pend_q <= pend_n;
    end
  end

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_take |=> (cnt_q == '0));

  assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> (cnt_q < ratio));

  assert_hold_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !src_rise |=> ($stable(cnt_q) && $stable(div_q)));

endmodule

// File: rtl/clkout_div_top.sv
module clkout_div_top
  import clkout_div_pkg::*;
#(
  parameter int unsigned PRE_TOP_RATIO = 122
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_slow,
  input  logic             src_fast,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             clk_out
);

  localparam int unsigned PRE_MAX   = max_u(PRE_TOP_RATIO, 32'd1 << ((1 << PRE_W) - 2));
  localparam int unsigned MAX_RATIO = PRE_MAX << ((1 << POST_W) - 1);
  localparam int unsigned RAT_W     = $clog2(MAX_RATIO + 1);

  cfg_t             cfg_q;
  logic             restart_req;
  logic             sel_level;
  logic             sel_rise;
  logic             div_q;
  logic [RAT_W-1:0] ratio;
  logic [RAT_W-1:0] half;
  logic             bypass;

  clkout_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .cfg_q       (cfg_q),
    .restart_req (restart_req)
  );

  clkout_src_edge #(.NUM_SRC(2)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    ({src_fast, src_slow}),
    .sel       (cfg_q.sel),
    .sel_level (sel_level),
    .sel_rise  (sel_rise)
  );

  assign ratio  = RAT_W'(total_ratio(cfg_q, PRE_TOP_RATIO));
  assign half   = ratio >> 1;
  assign bypass = (ratio == RAT_W'(1));

  clkout_div_core #(.RAT_W(RAT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_rise    (sel_rise),
    .restart_req (restart_req),
    .ratio       (ratio),
    .half        (half),
    .div_q       (div_q)
  );

  assign rd_data = CFG_W'(cfg_q);
  assign clk_out = cfg_q.en & (bypass ? sel_level : div_q);

  assert_ratio_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != '0) && (ratio <= RAT_W'(MAX_RATIO)));

endmodule

// File: tb/clkout_div_top_tb_top.sv
module clkout_div_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_slow = 1'b0;
  logic       src_fast = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;
  wire        clk_out;

  always #10 clk = ~clk;

  clkout_div_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_slow(src_slow), .src_fast(src_fast),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // Arithmetic model: edge index since the last restart
  logic [7:0] m_cfg = 8'h00;
  bit m_pend = 1'b1;
  int m_k = 0;
  bit m_div = 1'b0;
  bit m_exp = 1'b0;
  int cyc_no = 0;
  int win_bad = 0;
  bit win_act, win_exp;
  int run_cur = 0, run_last = 0;

  function automatic int ratio_of(logic [7:0] c);
    int pr;
    pr = (c[7:5] == 3'd7) ? 122 : (1 << c[7:5]);
    if (!c[4]) pr = 1;
    return pr * (1 << c[3:1]);
  endfunction

  function automatic logic [6:0] eff_of(logic [7:0] c);
    return {c[4], c[3:1], (c[4] ? c[7:5] : 3'b000)};
  endfunction

  function automatic bit exp_now();
    bit lvl;
    lvl = m_cfg[4] ? src_fast : src_slow;
    if (!m_cfg[0]) return 1'b0;
    return (ratio_of(m_cfg) == 1) ? lvl : m_div;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic sample();
    if (clk_out !== m_exp) begin
      if (win_bad == 0) begin win_act = clk_out; win_exp = m_exp; end
      win_bad++;
    end
    if (clk_out === 1'b1) run_cur++;
    else begin
      if (run_cur > 0) run_last = run_cur;
      run_cur = 0;
    end
  endtask

  task automatic cyc();
    bit nf, ns, rise;
    int n;
    @(negedge clk);
    sample();
    wr_en = 1'b0;
    cyc_no++;
    nf = ~src_fast;
    ns = (cyc_no % 4 == 0) ? ~src_slow : src_slow;
    rise = m_cfg[4] ? (nf & ~src_fast) : (ns & ~src_slow);
    src_fast = nf;
    src_slow = ns;
    n = ratio_of(m_cfg);
    if (rise) begin
      if (m_pend) begin m_k = 0; m_pend = 1'b0; end
      else m_k++;
      m_div = ((m_k % n) < (n / 2));
    end
    m_exp = exp_now();
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk);
    sample();
    wr_en = 1'b1;
    wr_data = v;
    if (eff_of(v) != eff_of(m_cfg)) m_pend = 1'b1;
    m_cfg = v;
    m_exp = exp_now();
  endtask

  task automatic win_start();
    win_bad = 0; run_cur = 0; run_last = 0;
  endtask

  task automatic win_end(string req, string what);
    check(win_bad == 0, req, what, int'(win_act), int'(win_exp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1..all watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data === 8'h00, "R11", "reset register", int'(rd_data), 0);
    check(clk_out === 1'b0, "R11", "reset output", int'(clk_out), 0);

    win_start(); cycles(20); win_end("R11", "idle after reset stays low");

    // R10 readback of arbitrary values
    wr(8'hA5); cyc(); check(rd_data === 8'hA5, "R10", "readback A5", int'(rd_data), 8'hA5);
    cycles(5);
    wr(8'h5A); cyc(); check(rd_data === 8'h5A, "R10", "readback 5A", int'(rd_data), 8'h5A);
    cycles(5);
    wr(8'hFE); cyc(); check(rd_data === 8'hFE, "R10", "readback FE", int'(rd_data), 8'hFE);
    cycles(5);

    // Sweep: low-speed source over post codes, high-speed over all codes
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 8; p++) begin
        for (int q = 0; q < 8; q++) begin
          logic [7:0] v;
          int n, per, c;
          string lbl;
          if (s == 0 && p != 0) continue;
          v = {3'(p), 1'(s), 3'(q), 1'b1};
          n = ratio_of(v);
          per = s ? 2 : 8;
          c = 2 * n * per + 2 * per;
          if (c > 600) c = 600;
          if (n == 1)      lbl = "R9";
          else if (s == 0) lbl = "R6";
          else if (p == 7) lbl = "R4";
          else             lbl = "R3";
          wr(v);
          win_start(); cycles(c); win_end(lbl, $sformatf("sweep cfg %02h", v));
        end
      end
    end

    // R7 duty: ratio 122 high for 61 fast periods (122 clk)
    wr(8'hF1); cycles(10);
    win_start(); cycles(700);
    check(run_last == 122, "R7", "high time ratio 122", run_last, 122);
    win_end("R4", "ratio 122 waveform");
    // R7 slow ratio 8: high 4 slow periods (32 clk)
    wr(8'h07); cycles(10);
    win_start(); cycles(200);
    check(run_last == 32, "R7", "high time slow ratio 8", run_last, 32);
    win_end("R7", "slow ratio 8 waveform");

    // R5 pre field ignored on the low-speed source
    wr(8'h05); cycles(40);
    win_start();
    for (int i = 0; i < 3; i++) begin
      cycles(7 + 3 * i);
      wr({3'(i + 2), 1'b0, 3'd2, 1'b1});
    end
    cycles(60);
    win_end("R5", "slow pre-field writes no phase change");

    // R8 restart on ratio change
    wr(8'h17); cycles(13);
    win_start(); wr(8'h15); cycles(40); win_end("R8", "restart on post change");
    win_start();
    cycles(5); wr(8'h15); cycles(7); wr(8'h15); cycles(30);
    win_end("R8", "identical rewrite keeps phase");
    win_start(); cycles(3); wr(8'h35); cycles(40); win_end("R8", "fast pre change restarts");

    // R1 enable gating, phase kept
    wr(8'h34); win_start(); cycles(30); win_end("R1", "disabled output low");
    wr(8'h35); win_start(); cycles(9); wr(8'h34); cycles(5); wr(8'h35); cycles(30);
    win_end("R1", "re-enable resumes phase");

    // R2 source selection in pass-through
    wr(8'h01); win_start(); cycles(40); win_end("R2", "slow source selected");
    wr(8'h11); win_start(); cycles(40); win_end("R2", "fast source selected");

    cyc();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule